// File: doc/BRIEF.md
# Accumulator Flag ALU

This block computes the single-operand accumulator operations of a small 8-bit processor core together with the exact next state of its four condition flags. The operations are increment, decrement, four rotates (circular and through-carry, in both directions), decimal adjust after a BCD add or subtract, bitwise complement, and setting or toggling the carry. The flags are zero (Z), subtract (N), half-carry (H) and carry (C).

Each clock the caller presents an operation code, an 8-bit operand and the current flags. One cycle later the block presents the result, the full next flag vector and a per-flag write-enable vector. A flag that the operation does not touch appears on the flag output with its incoming value, and its write enable is low. The register-file owner decides what to commit. All outputs are registered and cleared by a synchronous active-high reset.

Top module: `alu8_flag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_q`, `flags_q` and `flag_we_q` become zero on that edge, whatever the inputs are. Otherwise each output reflects the inputs sampled at the previous rising edge. Flag vectors are ordered {Z,N,H,C}, with Z at bit 3 and C at bit 0.
- R2: `op`=0 (increment) gives `operand`+1 modulo 256. Z is set when the result is 0, N is cleared, and H is set exactly when the operand's low nibble is 0xF. The enables are 4'b1110, so C is not written.
- R3: `op`=1 (decrement) gives `operand`-1 modulo 256. Z is set when the result is 0, N is set, and H is set exactly when the operand's low nibble is 0x0. The enables are 4'b1110, so C is not written.
- R4: `op`=2 (rotate left circular) moves old bit 7 into both bit 0 and C. `op`=3 (rotate right circular) moves old bit 0 into both bit 7 and C.
- R5: `op`=4 (rotate left through carry) moves the old C into bit 0 and old bit 7 into C. `op`=5 (rotate right through carry) moves the old C into bit 7 and old bit 0 into C.
- R6: All four rotates clear Z, N and H regardless of the result, and write all four flags (enables 4'b1111).
- R7: With `op`=6 (decimal adjust) and incoming N=0, the correction is taken from the unadjusted operand. 0x60 is added, and C is set, when C is set or the operand exceeds 0x99; otherwise C is cleared. 0x06 is added when H is set or the low nibble exceeds 9. Z follows the 8-bit result, H is cleared, and the enables are 4'b1011.
- R8: With `op`=6 and incoming N=1, 0x06 is subtracted when H is set and 0x60 when C is set. C keeps its value, Z follows the result, H is cleared, and the enables are 4'b1011.
- R9: `op`=7 (complement) returns the bitwise inverse of the operand and sets N and H. The enables are 4'b0110.
- R10: `op`=8 (set carry) and `op`=9 (toggle carry) return the operand unchanged, clear N and H, and set C to 1 or to the inverse of the old C respectively. The enables are 4'b0111.
- R11: Operation codes 10 to 15 return the operand unchanged with all enables low.
- R12: Every flag whose enable is low is presented on `flags_q` with the value `flags_in` had when the inputs were sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| operand | input | 8 | Accumulator or register value |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| res_q | output | 8 | Registered result |
| flags_q | output | 4 | Registered next flags {Z,N,H,C} |
| flag_we_q | output | 4 | Registered per-flag write enables {Z,N,H,C} |

## Verification
The bench sweeps every operation code against every operand and every incoming flag combination. This covers the nibble boundaries 0x0F/0x10 and 0x00/0xFF, where a half-carry computed from the wrong nibble value, or a carry wrongly written by increment or decrement, would show up as a flipped H or a C enable. It also covers decimal adjust on operands above 0x99 and with the flags preset. A correction evaluated on the partly adjusted value, or a carry cleared after subtraction, gives wrong BCD digits or a lost C there. The rotates with the old carry both set and clear catch a through-carry rotate that uses the new carry instead, and rotate results of zero catch a Z flag computed from the result. Unused codes and untouched flags are checked for pass-through, which exposes stale or zeroed flag bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 4;

  // flag bit positions inside the {Z,N,H,C} vector
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  localparam logic [NIB_W-1:0] BCD_LIMIT = NIB_W'(9);
  localparam logic [NIB_W-1:0] BCD_FIX   = NIB_W'(6);

  typedef enum logic [OP_W-1:0] {
    OP_INC  = 4'd0,
    OP_DEC  = 4'd1,
    OP_RLC  = 4'd2,
    OP_RRC  = 4'd3,
    OP_RL   = 4'd4,
    OP_RR   = 4'd5,
    OP_DAA  = 4'd6,
    OP_CPL  = 4'd7,
    OP_SCF  = 4'd8,
    OP_CCF  = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic [FLAG_W-1:0] flg;
    logic [FLAG_W-1:0] we;
  } alu_out_t;
endpackage

// File: rtl/alu8_incdec.sv
module alu8_incdec
  import alu8_pkg::*;
(
  input  logic              is_dec,
  input  logic [DATA_W-1:0] a,
  output alu_out_t          o
);
  logic [DATA_W-1:0] sum;

  always_comb begin
    sum = is_dec ? a - DATA_W'(1) : a + DATA_W'(1);
    o.res = sum;
    o.flg = '0;
    o.flg[FZ] = (sum == '0);
    o.flg[FN] = is_dec;
    // half-carry out of the low nibble on +1, borrow into it on -1
    o.flg[FH] = is_dec ? (a[NIB_W-1:0] == '0) : (a[NIB_W-1:0] == '1);
    o.we = '1;
    o.we[FC] = 1'b0;
  end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate
  import alu8_pkg::*;
(
  input  logic              go_right,
  input  logic              thru_carry,
  input  logic              c_old,
  input  logic [DATA_W-1:0] a,
  output alu_out_t          o
);
  logic fill;
  logic spill;

  always_comb begin
    spill = go_right ? a[0] : a[DATA_W-1];
    fill  = thru_carry ? c_old : spill;
    o.res = go_right ? {fill, a[DATA_W-1:1]} : {a[DATA_W-2:0], fill};
    o.flg = '0;
    o.flg[FC] = spill;
    o.we  = '1;
  end
endmodule

// File: rtl/alu8_adjust.sv
module alu8_adjust
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [FN:0]       f,
  output alu_out_t          o
);
  logic              lo_over;
  logic              hi_over;
  logic              fix_lo;
  logic              fix_hi;
  logic [DATA_W-1:0] corr;
  logic [DATA_W-1:0] bcd;

  always_comb begin
    lo_over = a[NIB_W-1:0] > BCD_LIMIT;
    hi_over = a > {BCD_LIMIT, BCD_LIMIT};
    fix_lo  = f[FH] | (~f[FN] & lo_over);
    fix_hi  = f[FC] | (~f[FN] & hi_over);
    corr    = {fix_hi ? BCD_FIX : '0, fix_lo ? BCD_FIX : '0};
    bcd     = f[FN] ? a - corr : a + corr;

    o.res = a;
    o.flg = '0;
    o.we  = '0;
    unique case (op)
      OP_DAA: begin
        o.res     = bcd;
        o.flg[FZ] = (bcd == '0);
        o.flg[FC] = fix_hi;
        o.we      = 4'b1011;
      end
      OP_CPL: begin
        o.res     = ~a;
        o.flg[FN] = 1'b1;
        o.flg[FH] = 1'b1;
        o.we      = 4'b0110;
      end
      OP_SCF: begin
        o.flg[FC] = 1'b1;
        o.we      = 4'b0111;
      end
      OP_CCF: begin
        o.flg[FC] = ~f[FC];
        o.we      = 4'b0111;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] operand,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] res_q,
  output logic [FLAG_W-1:0] flags_q,
  output logic [FLAG_W-1:0] flag_we_q
);
  alu_out_t incdec_o;
  alu_out_t rot_o;
  alu_out_t adj_o;
  alu_out_t pick;
  logic [FLAG_W-1:0] flags_next;

  alu8_incdec u_incdec (
    .is_dec (op == OP_DEC),
    .a      (operand),
    .o      (incdec_o)
  );

  alu8_rotate u_rotate (
    .go_right   (op == OP_RRC || op == OP_RR),
    .thru_carry (op == OP_RL  || op == OP_RR),
    .c_old      (flags_in[FC]),
    .a          (operand),
    .o          (rot_o)
  );

  alu8_adjust u_adjust (
    .op  (op),
    .a   (operand),
    .f   (flags_in[FN:0]),
    .o   (adj_o)
  );

  always_comb begin
    case (op)
      OP_INC, OP_DEC:               pick = incdec_o;
      OP_RLC, OP_RRC, OP_RL, OP_RR: pick = rot_o;
      default:                      pick = adj_o;
    endcase
    flags_next = (pick.we & pick.flg) | (~pick.we & flags_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q     <= '0;
      flags_q   <= '0;
      flag_we_q <= '0;
    end else begin
      res_q     <= pick.res;
      flags_q   <= flags_next;
      flag_we_q <= pick.we;
    end
  end

  // R2 R3
  incdec_carry_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op) == OP_INC || $past(op) == OP_DEC))
      |-> (!flag_we_q[FC] && flags_q[FC] == $past(flags_in[FC])));

  // R6
  rotate_clears_znh_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) >= OP_RLC && $past(op) <= OP_RR)
      |-> (flags_q[FZ:FH] == 3'b000));

  // R7 R8
  daa_h_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_DAA)
      |-> (!flags_q[FH] && flags_q[FN] == $past(flags_in[FN])));

  // R9
  cpl_inverts_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_CPL) |-> (res_q == ~$past(operand)));

  // R11
  unused_op_passive_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) > OP_CCF)
      |-> (flag_we_q == '0 && res_q == $past(operand)));

  // R12
  unwritten_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flags_q & ~flag_we_q) == ($past(flags_in) & ~flag_we_q)));
endmodule

// File: tb/alu8_flag_unit_tb_top.sv
module alu8_flag_unit_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = '0;
  logic [7:0] operand = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] res_q;
  logic [3:0] flags_q;
  logic [3:0] flag_we_q;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  bit         pend = 0;
  logic [7:0] exp_res;
  logic [3:0] exp_flg;
  logic [3:0] exp_we;
  logic [3:0] prev_f;
  logic [3:0] prev_op;
  string      prev_tag;

  always #(CLK_P/2) clk = ~clk;

  alu8_flag_unit dut_i (
    .clk(clk), .rst(rst), .op(op), .operand(operand), .flags_in(flags_in),
    .res_q(res_q), .flags_q(flags_q), .flag_we_q(flag_we_q)
  );

  // behavioural reference: returns {result, flags, enables}
  function automatic logic [15:0] model(input int o, input int a, input logic [3:0] f);
    int r = a;
    logic z = f[3], n = f[2], h = f[1], c = f[0];
    logic [3:0] w = 4'b0000;
    case (o)
      0: begin r = (a + 1) % 256; z = (r == 0); n = 0; h = (a % 16 == 15); w = 4'b1110; end
      1: begin r = (a + 255) % 256; z = (r == 0); n = 1; h = (a % 16 == 0); w = 4'b1110; end
      2: begin c = (a >= 128); r = (a * 2) % 256 + (c ? 1 : 0); end
      3: begin c = (a % 2 == 1); r = a / 2 + (c ? 128 : 0); end
      4: begin r = (a * 2) % 256 + (f[0] ? 1 : 0); c = (a >= 128); end
      5: begin r = a / 2 + (f[0] ? 128 : 0); c = (a % 2 == 1); end
      6: begin
        if (!f[2]) begin
          c = 0;
          if (f[0] || a > 153) begin r += 96; c = 1; end
          if (f[1] || (a % 16) > 9) r += 6;
        end else begin
          if (f[1]) r -= 6;
          if (f[0]) r -= 96;
        end
        r = (r + 512) % 256; z = (r == 0); h = 0; w = 4'b1011;
      end
      7: begin r = 255 - a; n = 1; h = 1; w = 4'b0110; end
      8: begin n = 0; h = 0; c = 1; w = 4'b0111; end
      9: begin n = 0; h = 0; c = ~f[0]; w = 4'b0111; end
      default: ;
    endcase
    if (o >= 2 && o <= 5) begin z = 0; n = 0; h = 0; w = 4'b1111; end
    return {r[7:0], z, n, h, c, w};
  endfunction

  function automatic string tag_of(input int o, input logic nf);
    case (o)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6: return nf ? "R8" : "R7";
      7: return "R9";
      8, 9: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check_prev();
    if (!pend) return;
    n_checks++;
    if (res_q !== exp_res || flags_q !== exp_flg || flag_we_q !== exp_we) begin
      n_fail++;
      $display("FAIL %s op=%0d: got res=%h flg=%b we=%b, expected res=%h flg=%b we=%b",
               prev_tag, prev_op, res_q, flags_q, flag_we_q, exp_res, exp_flg, exp_we);
    end
    if (prev_op >= 2 && prev_op <= 5) begin
      n_checks++;
      if (flags_q[3:1] !== 3'b000) begin
        n_fail++;
        $display("FAIL R6 op=%0d: got ZNH=%b, expected 000", prev_op, flags_q[3:1]);
      end
    end
    n_checks++;
    if ((flags_q & ~exp_we) !== (prev_f & ~exp_we)) begin
      n_fail++;
      $display("FAIL R12 op=%0d: got untouched=%b, expected %b",
               prev_op, flags_q & ~exp_we, prev_f & ~exp_we);
    end
  endtask

  task automatic apply(input int o, input int a, input logic [3:0] f);
    logic [15:0] m;
    @(negedge clk);
    check_prev();
    op = 4'(o); operand = 8'(a); flags_in = f;
    m = model(o, a, f);
    exp_res = m[15:8]; exp_flg = m[7:4]; exp_we = m[3:0];
    prev_f = f; prev_op = 4'(o); prev_tag = tag_of(o, f[2]);
    pend = 1;
  endtask

  initial begin
    // R1: reset dominates non-zero inputs
    op = 4'd0; operand = 8'h0F; flags_in = 4'b1111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (res_q !== 8'h00 || flags_q !== 4'h0 || flag_we_q !== 4'h0) begin
      n_fail++;
      $display("FAIL R1 reset: got res=%h flg=%b we=%b, expected 00 0000 0000",
               res_q, flags_q, flag_we_q);
    end
    rst = 1'b0;
    // directed corners
    apply(0, 8'h0F, 4'b0001);  // R2 half-carry, C kept
    apply(0, 8'hFF, 4'b0000);  // R2 wrap to zero
    apply(1, 8'h10, 4'b0001);  // R3 borrow from nibble
    apply(1, 8'h01, 4'b0000);  // R3 zero result
    apply(2, 8'h80, 4'b1000);  // R4
    apply(5, 8'h00, 4'b0001);  // R5 carry into bit 7
    apply(4, 8'h00, 4'b0000);  // R6 zero result still Z=0
    apply(6, 8'h9A, 4'b0000);  // R7 -> 00 with C
    apply(6, 8'h45, 4'b0111);  // R8 subtract both corrections
    apply(7, 8'h5A, 4'b1001);  // R9
    apply(9, 8'h33, 4'b0001);  // R10
    apply(12, 8'hC3, 4'b1010); // R11
    // exhaustive sweep
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int f = 0; f < 16; f++)
          apply(o, a, 4'(f));
    @(negedge clk);
    check_prev();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule